// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block carries words between two sides, called A and B, with a separate path in each direction. Each path has one storage element. While the path's latch-enable input is high, the storage passes data straight through. While it is low, the storage holds its value and takes a new sample only when the path's capture strobe rises. Each path also has a drive-enable. The A-to-B enable is active high and the B-to-A enable is active low. Each driven side is modelled as a data bus plus a drive flag, so no tristate nets are used.

The design runs on one system clock. A rise of a capture strobe is seen when the strobe is high at a system clock edge after being low at the previous edge. Transparency is combinational. The stored value follows the input at every system edge while the latch is open. After the latch closes, the stored value is the input sampled at the last system edge at which the latch was open.

Each data input has a bus keeper. A companion flag tells whether the outside world is driving the input. When nothing drives it, the input is taken from a register that holds the last effective value.

Top module: `xcvr_latreg`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A input in the same cycle.
- R2: While `ab_le` is 0, `b_out` does not change at a system edge unless `ab_ck` rose at that edge (`ab_ck` is 1 at the edge and was 0 at the previous edge).
- R3: While `ab_le` is 0, a rise of `ab_ck` stores the effective A input at that edge, and `b_out` shows it from then on.
- R4: When `ab_le` falls, `b_out` keeps the effective A input that was sampled at the last system edge while `ab_le` was 1.
- R5: `b_out_en` equals `ab_oe`, which is active high.
- R6: The B-to-A path follows R1 to R4 using `ba_le`, `ba_ck`, `b_in` and `a_out`. Its enable `ba_oe_n` is active low, and `a_out_en` equals the inverse of `ba_oe_n`.
- R7: When `a_in_drv` is 1, the effective A input is `a_in`. When `a_in_drv` is 0, the effective A input is the effective A value registered at the previous system edge. `b_in_drv` works the same way for the B input.
- R8: While `rst_n` is 0, both storage elements, both keeper registers and both strobe history bits are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | WIDTH | A-side data input |
| a_in_drv | input | 1 | 1 when A input is externally driven |
| b_in | input | WIDTH | B-side data input |
| b_in_drv | input | 1 | 1 when B input is externally driven |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B latch open |
| ab_ck | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch open |
| ba_ck | input | 1 | B-to-A capture strobe |
| b_out | output | WIDTH | Data driven onto B side |
| b_out_en | output | 1 | B side drive flag |
| a_out | output | WIDTH | Data driven onto A side |
| a_out_en | output | 1 | A side drive flag |

## Verification
The bench builds the block at its default width of 18. At that width, random words use all bit positions, so a swapped or dropped bit shows up in the output. Random sequences of latch, strobe, enable and keeper-drive levels reach the cases that matter. These include a latch closing in the same cycle as a strobe rise, a strobe held high across several edges, and an undriven input feeding an open latch. The two enables are also toggled on their own, so each one's polarity is checked separately and cycles with both sides driving can be counted.

// File: rtl/xcvr_latreg.sv
module xcvr_latreg #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_in_drv,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_in_drv,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_ck,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_ck,
  output logic [WIDTH-1:0] b_out,
  output logic             b_out_en,
  output logic [WIDTH-1:0] a_out,
  output logic             a_out_en
);

  logic [WIDTH-1:0] a_keep, b_keep, a_eff, b_eff;
  logic [WIDTH-1:0] ab_store, ba_store;
  logic             ab_ck_q, ba_ck_q;
  logic             ab_take, ba_take;

  assign a_eff   = a_in_drv ? a_in : a_keep;
  assign b_eff   = b_in_drv ? b_in : b_keep;
  assign ab_take = ab_le | (ab_ck & ~ab_ck_q);
  assign ba_take = ba_le | (ba_ck & ~ba_ck_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_keep   <= '0;
      b_keep   <= '0;
      ab_store <= '0;
      ba_store <= '0;
      ab_ck_q  <= 1'b0;
      ba_ck_q  <= 1'b0;
    end else begin
      a_keep  <= a_eff;
      b_keep  <= b_eff;
      ab_ck_q <= ab_ck;
      ba_ck_q <= ba_ck;
      if (ab_take) ab_store <= a_eff;
      if (ba_take) ba_store <= b_eff;
    end
  end

  assign b_out    = ab_le ? a_eff : ab_store;
  assign a_out    = ba_le ? b_eff : ba_store;
  assign b_out_en = ab_oe;
  assign a_out_en = ~ba_oe_n;

  // R1 / R4: open latch tracks the input
  a_r1_track: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |=> ab_store == $past(a_eff));
  // R2: closed latch without a strobe rise holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !(ab_ck && !ab_ck_q)) |=> $stable(ab_store));
  // R3: strobe rise captures
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_ck && !ab_ck_q) |=> ab_store == $past(a_eff));
  // R6: mirrored path
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !(ba_ck && !ba_ck_q)) |=> $stable(ba_store));
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le || (ba_ck && !ba_ck_q)) |=> ba_store == $past(b_eff));
  // R7: keeper registers the driven value
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    a_in_drv |=> a_keep == $past(a_in));
  a_r7_float: assert property (@(posedge clk) disable iff (!rst_n)
    !b_in_drv |=> $stable(b_keep));

endmodule

// File: tb/xcvr_latreg_tb.sv
module xcvr_latreg_tb;
  localparam int W = 18;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_in_drv = 0, b_in_drv = 0, ab_oe = 0, ab_le = 0, ab_ck = 0;
  logic ba_oe_n = 1, ba_le = 0, ba_ck = 0;
  logic [W-1:0] b_out, a_out;
  logic b_out_en, a_out_en;

  int checks = 0, failures = 0, clashes = 0;
  logic [W-1:0] m_ka = '0, m_kb = '0, m_sab = '0, m_sba = '0;
  logic m_pab = 0, m_pba = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xcvr_latreg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_drv(a_in_drv),
    .b_in(b_in), .b_in_drv(b_in_drv), .ab_oe(ab_oe), .ab_le(ab_le),
    .ab_ck(ab_ck), .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
    .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive inputs after a falling edge, compare, then advance the model at the rising edge
  task automatic step(input logic [W-1:0] ai, input logic ad, input logic [W-1:0] bi, input logic bd,
                      input logic oe, input logic le, input logic ck,
                      input logic oen, input logic le2, input logic ck2);
    logic [W-1:0] ea, eb;
    @(negedge clk);
    a_in = ai; a_in_drv = ad; b_in = bi; b_in_drv = bd;
    ab_oe = oe; ab_le = le; ab_ck = ck; ba_oe_n = oen; ba_le = le2; ba_ck = ck2;
    #1;
    ea = ad ? ai : m_ka;
    eb = bd ? bi : m_kb;
    if (le) chk("R1 R7", b_out, ea); else chk("R2 R3 R4", b_out, m_sab);
    if (le2) chk("R6 R7", a_out, eb); else chk("R6", a_out, m_sba);
    chk("R5", {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, oe});
    chk("R6", {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, ~oen});
    if (oe && !oen) clashes++;
    @(posedge clk);
    if (rst_n) begin
      if (le || (ck && !m_pab)) m_sab = ea;
      if (le2 || (ck2 && !m_pba)) m_sba = eb;
      m_ka = ea; m_kb = eb; m_pab = ck; m_pba = ck2;
    end
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", b_out, '0);
    chk("R8", a_out, '0);
    @(negedge clk); rst_n = 1;
    // R1 transparency A to B
    step(18'h2A5A5, 1, 0, 0, 1, 1, 0, 1, 0, 0);
    step(18'h15A5A, 1, 0, 0, 1, 1, 0, 1, 0, 0);
    // R4 close latch, then R2 hold with strobe low and high
    step(18'h3FFFF, 1, 0, 0, 1, 0, 0, 1, 0, 0);
    chk("R4", b_out, 18'h15A5A);
    step(18'h00001, 1, 0, 0, 1, 0, 0, 1, 0, 0);
    // R3 strobe rise then held high
    step(18'h12345, 1, 0, 0, 1, 0, 1, 1, 0, 0);
    step(18'h0BEEF, 1, 0, 0, 1, 0, 1, 1, 0, 0);
    chk("R3", b_out, 18'h12345);
    step(18'h0BEEF, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    // R7 undriven A feeding open latch keeps last effective value
    step(18'h00000, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R7", b_out, 18'h0BEEF);
    // R6 B to A, active-low enable
    step(0, 0, 18'h1C0DE, 1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 18'h2FACE, 1, 0, 0, 0, 0, 0, 0);
    chk("R6", a_out, 18'h1C0DE);
    step(0, 0, 18'h31111, 1, 1, 0, 0, 0, 0, 1);
    step(0, 0, 18'h02222, 0, 1, 0, 0, 1, 0, 1);
    chk("R6", a_out, 18'h31111);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      v = rnd();
      step(v, $urandom_range(0, 3) != 0, rnd(), $urandom_range(0, 3) != 0,
           1'($urandom), $urandom_range(0, 3) == 0, 1'($urandom),
           1'($urandom), $urandom_range(0, 3) == 0, 1'($urandom));
    end
    // R8 reset in the middle
    @(negedge clk); rst_n = 0; ab_le = 0; ba_le = 0; a_in_drv = 0; b_in_drv = 0;
    m_ka = '0; m_kb = '0; m_sab = '0; m_sba = '0; m_pab = 0; m_pba = 0;
    #1;
    chk("R8", b_out, '0);
    chk("R8", a_out, '0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    chk("R8", b_out, '0);
    $display("both-sides-driving cycles seen: %0d", clashes);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule